// File: doc/BRIEF.md
# Operand predicate mask lookup

This block turns an operand register number into an element-enable mask for a vector operation. It keeps two small predication tables, one consulted for integer operands and one for floating-point operands, so the two kinds of operand can be predicated independently. Each table entry holds four fields: an enable flag, an invert flag, a zeroing flag and the number of an integer register that holds the mask bits.

On a lookup, the block puts the selected entry's source register number on a read port to the integer register file. It shapes the returned value into the mask in the same cycle. When the entry is not enabled, every element is enabled and zeroing is off. An enabled entry also predicates operands that are used as scalars, so the only way to switch predication off for a register is to clear its entry's enable flag.

The mask is XLEN bits wide, one bit per element, so a vector can have at most XLEN elements. The tables are loaded through a synchronous write port and come out of reset with every entry disabled.

Top module: `pred_lookup`

## Requirements
- R1: After reset, every entry of both tables is disabled. Every lookup then returns `mask_out` all ones and `zero_out` low, and `rf_addr` is 0.
- R2: When the selected entry is disabled, `mask_out` is all ones and `zero_out` is low, whatever its invert, zeroing and source fields hold and whatever `rf_data` holds.
- R3: When the selected entry is enabled with invert clear, `mask_out` equals `rf_data` in the same cycle.
- R4: When the selected entry is enabled with invert set, `mask_out` is the bitwise complement of `rf_data` in the same cycle.
- R5: When the selected entry is enabled, `zero_out` equals the entry's zeroing flag.
- R6: `rf_addr` equals the source register field of the entry selected by `lk_fp`/`lk_reg`, combinationally in the same cycle.
- R7: `lk_fp`=0 selects the integer table and `lk_fp`=1 selects the floating-point table. A write with `wr_fp`=0 goes to the integer table and a write with `wr_fp`=1 goes to the floating-point table. A write to one table never changes what a lookup in the other table returns.
- R8: A write with `wr_en` high replaces entry `wr_idx` at the rising clock edge. A lookup of that entry in the write cycle still sees the old contents. With `wr_en` low, no entry changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Table write strobe |
| wr_fp | input | 1 | Write target: 0 integer table, 1 floating-point table |
| wr_idx | input | ENT_W | Entry number to write |
| wr_active | input | 1 | Enable flag to store |
| wr_invert | input | 1 | Invert flag to store |
| wr_zero | input | 1 | Zeroing flag to store |
| wr_src | input | IREG_W | Mask source register number to store |
| lk_fp | input | 1 | Lookup table: 0 integer, 1 floating-point |
| lk_reg | input | ENT_W | Operand register number to look up |
| rf_addr | output | IREG_W | Integer register file read address |
| rf_data | input | XLEN | Integer register file read data |
| mask_out | output | XLEN | Element enable mask |
| zero_out | output | 1 | Zeroing mode for disabled elements |

## Verification
Every lookup result is combinational. `rf_addr`, `mask_out` and `zero_out` all settle in the cycle where `lk_fp`/`lk_reg` and `rf_data` are applied. The bench drives inputs on the falling edge and samples one nanosecond later, before the next rising edge. A table write becomes visible only after the rising edge that follows the cycle in which `wr_en` is driven. The bench therefore checks the lookup once before that edge, where it expects the old contents, and again after it, where it expects the new ones. The bench models the register file as an arithmetic function of `rf_addr`, and it derives every expected mask from its own copy of the tables.

// File: rtl/pred_pkg.sv
package pred_pkg;

  typedef enum logic {
    FILE_INT = 1'b0,
    FILE_FP  = 1'b1
  } file_sel_e;

  localparam int NUM_FILES = 2;

  typedef struct packed {
    logic active;
    logic invert;
    logic zero;
  } pred_flags_t;

  localparam pred_flags_t FLAGS_OFF = '{active: 1'b0, invert: 1'b0, zero: 1'b0};

endpackage

// File: rtl/pred_table.sv
module pred_table
  import pred_pkg::*;
#(
  parameter int NENT   = 32,
  parameter int IREG_W = 5,
  parameter int ENT_W  = $clog2(NENT)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ENT_W-1:0]  w_idx,
  input  pred_flags_t       w_flags,
  input  logic [IREG_W-1:0] w_src,
  input  logic [ENT_W-1:0]  r_idx,
  output pred_flags_t       r_flags,
  output logic [IREG_W-1:0] r_src
);

  pred_flags_t       flags_q [NENT];
  logic [IREG_W-1:0] src_q   [NENT];

  for (genvar e = 0; e < NENT; e++) begin : g_ent
    logic hit;
    assign hit = we && (w_idx == ENT_W'(e));
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        flags_q[e] <= FLAGS_OFF;
        src_q[e]   <= '0;
      end else if (hit) begin
        flags_q[e] <= w_flags;
        src_q[e]   <= w_src;
      end
    end
  end

  assign r_flags = flags_q[r_idx];
  assign r_src   = src_q[r_idx];

endmodule

// File: rtl/pred_select.sv
module pred_select
  import pred_pkg::*;
#(
  parameter int IREG_W = 5
) (
  input  logic              fp_sel,
  input  pred_flags_t       int_flags,
  input  logic [IREG_W-1:0] int_src,
  input  pred_flags_t       fp_flags,
  input  logic [IREG_W-1:0] fp_src,
  output pred_flags_t       sel_flags,
  output logic [IREG_W-1:0] sel_src
);

  always_comb begin
    if (file_sel_e'(fp_sel) == FILE_FP) begin
      sel_flags = fp_flags;
      sel_src   = fp_src;
    end else begin
      sel_flags = int_flags;
      sel_src   = int_src;
    end
  end

endmodule

// File: rtl/pred_mask_gen.sv
module pred_mask_gen
  import pred_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  pred_flags_t     flags,
  input  logic [XLEN-1:0] src_val,
  output logic [XLEN-1:0] mask,
  output logic            zero_mode
);

  function automatic logic [XLEN-1:0] shape_mask(input logic act, input logic inv,
                                                 input logic [XLEN-1:0] v);
    logic [XLEN-1:0] r;
    if (!act)     r = '1;
    else if (inv) r = ~v;
    else          r = v;
    return r;
  endfunction

  assign mask      = shape_mask(flags.active, flags.invert, src_val);
  assign zero_mode = flags.active & flags.zero;

endmodule

// File: rtl/pred_lookup.sv
module pred_lookup
  import pred_pkg::*;
#(
  parameter int XLEN   = 64,
  parameter int NENT   = 32,
  parameter int IREG_W = 6,
  parameter int ENT_W  = $clog2(NENT)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_fp,
  input  logic [ENT_W-1:0]  wr_idx,
  input  logic              wr_active,
  input  logic              wr_invert,
  input  logic              wr_zero,
  input  logic [IREG_W-1:0] wr_src,
  input  logic              lk_fp,
  input  logic [ENT_W-1:0]  lk_reg,
  output logic [IREG_W-1:0] rf_addr,
  input  logic [XLEN-1:0]   rf_data,
  output logic [XLEN-1:0]   mask_out,
  output logic              zero_out
);

  pred_flags_t       w_flags;
  pred_flags_t       tab_flags [NUM_FILES];
  logic [IREG_W-1:0] tab_src   [NUM_FILES];
  pred_flags_t       sel_flags;
  logic [IREG_W-1:0] sel_src;
  logic              sel_active;
  logic              sel_invert;
  logic              sel_zero;

  assign w_flags = '{active: wr_active, invert: wr_invert, zero: wr_zero};

  for (genvar f = 0; f < NUM_FILES; f++) begin : g_file
    logic we_f;
    assign we_f = wr_en && (wr_fp == f[0]);
    pred_table #(.NENT(NENT), .IREG_W(IREG_W), .ENT_W(ENT_W)) u_tab (
      .clk    (clk),
      .rst_n  (rst_n),
      .we     (we_f),
      .w_idx  (wr_idx),
      .w_flags(w_flags),
      .w_src  (wr_src),
      .r_idx  (lk_reg),
      .r_flags(tab_flags[f]),
      .r_src  (tab_src[f])
    );
  end

  pred_select #(.IREG_W(IREG_W)) u_sel (
    .fp_sel   (lk_fp),
    .int_flags(tab_flags[0]),
    .int_src  (tab_src[0]),
    .fp_flags (tab_flags[1]),
    .fp_src   (tab_src[1]),
    .sel_flags(sel_flags),
    .sel_src  (sel_src)
  );

  assign sel_active = sel_flags.active;
  assign sel_invert = sel_flags.invert;
  assign sel_zero   = sel_flags.zero;
  assign rf_addr    = sel_src;

  pred_mask_gen #(.XLEN(XLEN)) u_gen (
    .flags    (sel_flags),
    .src_val  (rf_data),
    .mask     (mask_out),
    .zero_mode(zero_out)
  );

endmodule

// File: rtl/pred_lookup_chk.sv
module pred_lookup_chk #(
  parameter int XLEN   = 64,
  parameter int IREG_W = 6,
  parameter int ENT_W  = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic              lk_fp,
  input logic [ENT_W-1:0]  lk_reg,
  input logic [IREG_W-1:0] rf_addr,
  input logic [XLEN-1:0]   rf_data,
  input logic [XLEN-1:0]   mask_out,
  input logic              zero_out,
  input logic              sel_active,
  input logic              sel_invert,
  input logic              sel_zero
);

  // R2
  a_r2_inactive_open: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_active |-> (mask_out == {XLEN{1'b1}}) && !zero_out);

  // R3
  a_r3_pass_through: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_active && !sel_invert) |-> mask_out == rf_data);

  // R4
  a_r4_inverted: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_active && sel_invert) |-> mask_out == ~rf_data);

  // R5
  a_r5_zero_flag: assert property (@(posedge clk) disable iff (!rst_n)
    sel_active |-> zero_out == sel_zero);

  // R8
  a_r8_no_write_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> (!($stable(lk_fp) && $stable(lk_reg)) ||
                ($stable(rf_addr) && $stable(sel_active) && $stable(sel_invert) && $stable(sel_zero))));

endmodule

bind pred_lookup pred_lookup_chk #(.XLEN(XLEN), .IREG_W(IREG_W), .ENT_W(ENT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .wr_en     (wr_en),
  .lk_fp     (lk_fp),
  .lk_reg    (lk_reg),
  .rf_addr   (rf_addr),
  .rf_data   (rf_data),
  .mask_out  (mask_out),
  .zero_out  (zero_out),
  .sel_active(sel_active),
  .sel_invert(sel_invert),
  .sel_zero  (sel_zero)
);

// File: tb/sim_pred_lookup.sv
`timescale 1ns/100ps
module sim_pred_lookup;
  localparam int XL = 16;
  localparam int NE = 8;
  localparam int IW = 4;
  localparam int EW = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0, wr_fp = 1'b0, wr_active = 1'b0, wr_invert = 1'b0, wr_zero = 1'b0;
  logic [EW-1:0] wr_idx = '0, lk_reg = '0;
  logic [IW-1:0] wr_src = '0;
  logic          lk_fp = 1'b0;
  logic [IW-1:0] rf_addr;
  logic [XL-1:0] rf_data, mask_out;
  logic          zero_out;

  int errors = 0;
  int checks = 0;

  bit          sh_act [2][NE];
  bit          sh_inv [2][NE];
  bit          sh_zer [2][NE];
  int unsigned sh_src [2][NE];

  always #2.5 clk = ~clk;

  function automatic logic [XL-1:0] rf_val(input logic [IW-1:0] a);
    return XL'((32'(a) + 1) * 32'h1357) ^ 16'h8C21;
  endfunction

  assign rf_data = rf_val(rf_addr);

  pred_lookup #(.XLEN(XL), .NENT(NE), .IREG_W(IW)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_fp(wr_fp), .wr_idx(wr_idx),
    .wr_active(wr_active), .wr_invert(wr_invert), .wr_zero(wr_zero), .wr_src(wr_src),
    .lk_fp(lk_fp), .lk_reg(lk_reg), .rf_addr(rf_addr), .rf_data(rf_data),
    .mask_out(mask_out), .zero_out(zero_out)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // lookup one entry and compare with the shadow copy
  task automatic look(input int f, input int e, input string tag);
    logic [XL-1:0] m;
    @(negedge clk);
    lk_fp = f[0]; lk_reg = EW'(e);
    #1;
    chk(rf_addr == IW'(sh_src[f][e]), {tag, " R6 addr"}, rf_addr, sh_src[f][e]);
    if (!sh_act[f][e]) m = '1;
    else if (sh_inv[f][e]) m = ~rf_val(IW'(sh_src[f][e]));
    else m = rf_val(IW'(sh_src[f][e]));
    chk(mask_out == m, {tag, sh_act[f][e] ? (sh_inv[f][e] ? " R4 mask" : " R3 mask") : " R2 mask"},
        mask_out, m);
    chk(zero_out == (sh_act[f][e] & sh_zer[f][e]), {tag, " R5 zero"}, zero_out,
        sh_act[f][e] & sh_zer[f][e]);
  endtask

  task automatic put(input int f, input int e, input bit a, input bit i, input bit z, input int s);
    @(negedge clk);
    wr_en = 1'b1; wr_fp = f[0]; wr_idx = EW'(e);
    wr_active = a; wr_invert = i; wr_zero = z; wr_src = IW'(s);
    @(negedge clk);
    wr_en = 1'b0;
    sh_act[f][e] = a; sh_inv[f][e] = i; sh_zer[f][e] = z; sh_src[f][e] = s % 16;
  endtask

  task automatic sweep(input string tag);
    for (int f = 0; f < 2; f++)
      for (int e = 0; e < NE; e++) look(f, e, tag);
  endtask

  initial begin
    #(5 * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int f = 0; f < 2; f++)
      for (int e = 0; e < NE; e++) begin
        sh_act[f][e] = 0; sh_inv[f][e] = 0; sh_zer[f][e] = 0; sh_src[f][e] = 0;
      end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    sweep("R1 reset");

    for (int rnd = 0; rnd < 4; rnd++) begin
      for (int f = 0; f < 2; f++)
        for (int e = 0; e < NE; e++)
          put(f, e, ((e + rnd + f) % 3) != 0, ((e >> 1) ^ rnd) & 1, (e ^ f ^ rnd) & 1,
              (e * 3 + rnd * 5 + f * 7) % 16);
      sweep("R7 round");
    end

    // disabled entry with every other field set: still open, no zeroing
    put(0, 5, 1'b0, 1'b1, 1'b1, 9);
    look(0, 5, "R2 inactive");

    // write to the integer table only; floating-point entry keeps its contents
    put(1, 2, 1'b1, 1'b0, 1'b1, 11);
    put(0, 2, 1'b1, 1'b1, 1'b0, 3);
    look(1, 2, "R7 fp kept");
    look(0, 2, "R7 int new");

    // strobe low: nothing changes
    @(negedge clk);
    wr_en = 1'b0; wr_fp = 1'b0; wr_idx = 3'd2; wr_active = 1'b0; wr_src = 4'd7;
    @(negedge clk);
    look(0, 2, "R8 strobe low");

    // same-cycle lookup sees old contents, next cycle sees new
    @(negedge clk);
    lk_fp = 1'b0; lk_reg = 3'd4;
    wr_en = 1'b1; wr_fp = 1'b0; wr_idx = 3'd4;
    wr_active = 1'b1; wr_invert = 1'b1; wr_zero = 1'b1; wr_src = 4'd13;
    #1;
    chk(rf_addr == IW'(sh_src[0][4]), "R8 old addr", rf_addr, sh_src[0][4]);
    @(negedge clk);
    wr_en = 1'b0;
    #1;
    chk(rf_addr == 4'd13, "R8 new addr", rf_addr, 13);
    chk(mask_out == ~rf_val(4'd13), "R8 new mask", mask_out, ~rf_val(4'd13));
    chk(zero_out == 1'b1, "R8 new zero", zero_out, 1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule